// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block collects 64 active-low interrupt lines into one request to the processor. Each line passes through a synchronizer and then a per-source capture cell. Most sources are level-sensitive only. A few external and port-style sources can be switched to latch a falling edge instead. Software sees the state through a small 32-bit register port. The port holds two enable words, two pending words, one edge-select word and one vector word. The vector word gives the number of the lowest-numbered source that is both pending and enabled.

Sources do not map linearly onto bit positions. They are split between a high bank and a low bank, and several groups sit in descending bit order. Software writes a 1 to a pending bit to clear a latched edge. Level sources show the live, synchronized line state and cannot be cleared. Source number 0 is reserved, because vector value 0 means that nothing is pending.

Top module: `intc64_top`

## Requirements
- R1: After reset, every register reads 0x00000000 and `irq` is low, provided all source inputs are held high. The register addresses are: 0 high enable, 1 low enable, 2 high pending, 3 low pending, 4 vector, 5 edge select. Any other address reads 0.
- R2: The enable words read back exactly what was last written to them. A source can raise `irq` or appear in the vector only while its enable bit is 1. A disabled source still shows in its pending word.
- R3: Each source maps to one bank and one bit:
  - Source 0 maps to high bit 0.
  - Sources 1–15 map to high bit 16−s.
  - Sources 16–31 map to low bit 31−s.
  - Sources 32–47 map to high bit 63−s.
  - Sources 48–63 map to low bit s−32.
- R4: In level mode, a source's pending bit is 1 exactly while its synchronized input is low. Writing 1 to that bit has no effect.
- R5: In falling-edge mode, a 1-to-0 transition of the synchronized input sets the pending bit. The bit then stays set after the input returns high.
- R6: Writing a 1 to a pending bit clears a latched edge. Writing 0 to a pending bit leaves it unchanged.
- R7: Only some sources can use falling-edge mode. Sources 19–25 use edge-select bits 14 down to 8. Sources 48–63 use edge-select bits 31 down to 16. A 1 selects falling edge and a 0 selects level. All other edge-select bits read 0 and ignore writes (write 0xFFFFFFFF reads 0xFFFF7F00). Setting edge select has no effect on any other source.
- R8: The vector word carries a source number in bits 31:26, and its other bits read 0. That number is the lowest-numbered source that is pending and enabled, or 0 if there is none. Source 0 never becomes pending. Writes to the vector word are ignored.
- R9: `irq` is high exactly when some pending bit has its enable bit set.
- R10: Latency from an input change:
  - A level source's low input first shows on `irq` after the second rising clock edge.
  - A falling edge first shows on `irq` after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, committed on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| src_n | input | 64 | Active-low interrupt sources, asynchronous |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions check the following on every cycle:
- A latched edge stays set, unless a clear arrives with no new edge in the same cycle.
- A detected fall always latches.
- A clear empties the latch.
- The vector is zero exactly when `irq` is low.
- A nonzero vector always names an active source.
- Enable and edge-select writes land as written, with the non-capable edge bits masked off.

Some behaviours can only be shown by the bench's scenarios:
- The non-linear bank and bit mapping, which is swept over all 64 sources.
- Lowest-number priority across both banks.
- Cycle-exact synchronizer latency.
- The fact that level sources and non-capable sources ignore clears and edge selects.

// File: rtl/intc64_pkg.sv
package intc64_pkg;

   localparam int SRC_CNT = 64;
   localparam int WORD_W  = 32;

   typedef enum logic [2:0] {
      RA_EN_HI   = 3'd0,
      RA_EN_LO   = 3'd1,
      RA_PND_HI  = 3'd2,
      RA_PND_LO  = 3'd3,
      RA_VECTOR  = 3'd4,
      RA_EDGESEL = 3'd5
   } reg_addr_e;

   // Bank selection: 1 = high bank, 0 = low bank
   function automatic logic src_in_high(input int s);
      return (s < 16) || (s >= 32 && s < 48);
   endfunction

   // Bit position of a source inside its bank
   function automatic int src_bit(input int s);
      if (s == 0)      return 0;
      else if (s < 16) return 16 - s;
      else if (s < 32) return 31 - s;
      else if (s < 48) return 63 - s;
      else             return s - 32;
   endfunction

   // Sources allowed to use falling-edge capture
   function automatic logic src_edge_ok(input int s);
      return (s >= 19 && s <= 25) || (s >= 48);
   endfunction

   // Edge-select bit owned by an edge-capable source
   function automatic int src_edge_bit(input int s);
      return (s <= 25) ? (33 - s) : (79 - s);
   endfunction

   // Writable bits of the edge-select word
   function automatic logic [WORD_W-1:0] edge_wr_mask();
      logic [WORD_W-1:0] m;
      m = '0;
      for (int s = 0; s < SRC_CNT; s++)
         if (src_edge_ok(s)) m[src_edge_bit(s)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/intc64_sync.sv
module intc64_sync #(
   parameter int   W       = 8,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (STAGES < 2) $error("intc64_sync: STAGES must be at least 2");
      if (W < 1)      $error("intc64_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_VAL}};
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/intc64_edge_cell.sv
module intc64_edge_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic s_n,       // synchronized, active low
   input  logic edge_sel,  // 1 = falling edge, 0 = level low
   input  logic clr,       // write-one-to-clear strike
   output logic pend
);

   logic prev_q;
   logic lat_q;
   logic fall;

   assign fall = prev_q & ~s_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= s_n;
         if (!edge_sel)  lat_q <= 1'b0;
         else if (fall)  lat_q <= 1'b1;
         else if (clr)   lat_q <= 1'b0;
      end
   end

   assign pend = edge_sel ? lat_q : ~s_n;

   // R5: a detected fall in edge mode always latches
   p_fall_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel && fall |=> lat_q);

   // R5: a latched edge persists without a clear
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel && lat_q && !clr |=> lat_q);

   // R6: a clear with no competing fall empties the latch
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel && clr && !fall |=> !lat_q);

endmodule

// File: rtl/intc64_pick.sv
module intc64_pick #(
   parameter int N  = 64,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  act,
   output logic [IW-1:0] idx,
   output logic          any
);

   initial begin
      if (N < 2) $error("intc64_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (act[i]) idx = IW'(i);
   end

   assign any = |act;

endmodule

// File: rtl/intc64_top.sv
module intc64_top #(
   parameter int N_SRC       = 64,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_LSB     = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SRC-1:0]  src_n,
   output logic              irq
);
   import intc64_pkg::*;

   localparam int VEC_W = $clog2(N_SRC);
   localparam logic [DATA_W-1:0] EDGE_MASK = edge_wr_mask();

   initial begin
      if (N_SRC != SRC_CNT)          $error("intc64_top: N_SRC must be 64");
      if (DATA_W != WORD_W)          $error("intc64_top: DATA_W must be 32");
      if (ADDR_W < 3)                $error("intc64_top: ADDR_W must be at least 3");
      if (VEC_LSB + VEC_W != DATA_W) $error("intc64_top: vector field must end at the top bit");
   end

   logic [DATA_W-1:0] en_hi_q, en_lo_q, edge_q;
   logic [DATA_W-1:0] pnd_hi, pnd_lo;
   logic [N_SRC-1:0]  s_q, pend_src, en_src, act;
   logic [VEC_W-1:0]  vec_idx;
   logic              any_act;

   logic wr_en_hi, wr_en_lo, wr_edge, clr_hi, clr_lo;
   assign wr_en_hi = reg_wr && (reg_addr == ADDR_W'(RA_EN_HI));
   assign wr_en_lo = reg_wr && (reg_addr == ADDR_W'(RA_EN_LO));
   assign wr_edge  = reg_wr && (reg_addr == ADDR_W'(RA_EDGESEL));
   assign clr_hi   = reg_wr && (reg_addr == ADDR_W'(RA_PND_HI));
   assign clr_lo   = reg_wr && (reg_addr == ADDR_W'(RA_PND_LO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_hi_q <= '0;
         en_lo_q <= '0;
         edge_q  <= '0;
      end else begin
         if (wr_en_hi) en_hi_q <= reg_wdata;
         if (wr_en_lo) en_lo_q <= reg_wdata;
         if (wr_edge)  edge_q  <= reg_wdata & EDGE_MASK;
      end
   end

   intc64_sync #(.W(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_n), .q(s_q)
   );

   // Source 0 is reserved: vector value 0 means idle
   logic unused_src0;
   assign unused_src0 = s_q[0];
   assign pend_src[0] = 1'b0;

   for (genvar i = 1; i < N_SRC; i++) begin : g_src
      if (src_edge_ok(i)) begin : g_edge
         logic clr_i;
         assign clr_i = src_in_high(i) ? (clr_hi & reg_wdata[src_bit(i)])
                                       : (clr_lo & reg_wdata[src_bit(i)]);
         intc64_edge_cell u_cell (
            .clk(clk), .rst_n(rst_n), .s_n(s_q[i]),
            .edge_sel(edge_q[src_edge_bit(i)]), .clr(clr_i), .pend(pend_src[i])
         );
      end else begin : g_level
         assign pend_src[i] = ~s_q[i];
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_map
      if (src_in_high(i)) begin : g_hi
         assign pnd_hi[src_bit(i)] = pend_src[i];
         assign en_src[i]          = en_hi_q[src_bit(i)];
      end else begin : g_lo
         assign pnd_lo[src_bit(i)] = pend_src[i];
         assign en_src[i]          = en_lo_q[src_bit(i)];
      end
   end

   assign act = pend_src & en_src;

   intc64_pick #(.N(N_SRC)) u_pick (.act(act), .idx(vec_idx), .any(any_act));

   assign irq = any_act;

   always_comb begin
      case (reg_addr)
         ADDR_W'(RA_EN_HI):   reg_rdata = en_hi_q;
         ADDR_W'(RA_EN_LO):   reg_rdata = en_lo_q;
         ADDR_W'(RA_PND_HI):  reg_rdata = pnd_hi;
         ADDR_W'(RA_PND_LO):  reg_rdata = pnd_lo;
         ADDR_W'(RA_VECTOR):  reg_rdata = {vec_idx, {VEC_LSB{1'b0}}};
         ADDR_W'(RA_EDGESEL): reg_rdata = edge_q;
         default:             reg_rdata = '0;
      endcase
   end

   // R8: vector is zero exactly when no request is raised
   p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_idx == '0) == !irq);

   // R8: a raised request names an active source
   p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> act[vec_idx]);

   // R2: enable writes land as written
   p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_lo |=> en_lo_q == $past(reg_wdata));

   // R7: edge-select writes keep only the capable bits
   p_edge_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_edge |=> edge_q == ($past(reg_wdata) & EDGE_MASK));

endmodule

// File: tb/sim_intc64_top.sv
`timescale 1ns/1ps
module sim_intc64_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] src_n = '1;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   intc64_top u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_n(src_n), .irq(irq)
   );

   // Expected mapping, from R3 and R7
   function automatic logic x_hi(input int s);
      return (s < 16) || (s >= 32 && s < 48);
   endfunction
   function automatic int x_bit(input int s);
      if (s == 0) return 0;
      if (s < 16) return 16 - s;
      if (s < 32) return 31 - s;
      if (s < 48) return 63 - s;
      return s - 32;
   endfunction
   function automatic logic x_edge(input int s);
      return (s >= 19 && s <= 25) || s >= 48;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.1;
      d = reg_rdata;
   endtask

   task automatic chk_pend(input string tag, input int s, input logic on);
      logic [31:0] h, l, eh, el;
      eh = '0; el = '0;
      if (on) begin
         if (x_hi(s)) eh[x_bit(s)] = 1'b1;
         else         el[x_bit(s)] = 1'b1;
      end
      rd(3'd2, h); chk(tag, h, eh);
      rd(3'd3, l); chk(tag, l, el);
   endtask

   task automatic clear_bit(input int s);
      logic [31:0] m;
      m = '0;
      m[x_bit(s)] = 1'b1;
      wr(x_hi(s) ? 3'd2 : 3'd3, m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(a[2:0], v);
         chk("R1 reset register", v, 32'h0);
      end
      chk("R1 reset irq", {31'b0, irq}, 32'h0);

      // R2: enable readback
      wr(3'd0, 32'hA5C3_0F81); rd(3'd0, v); chk("R2 enable hi readback", v, 32'hA5C3_0F81);
      wr(3'd1, 32'h1234_FEDC); rd(3'd1, v); chk("R2 enable lo readback", v, 32'h1234_FEDC);

      // R2: disabled source pends but does not request
      wr(3'd0, 32'h0); wr(3'd1, 32'h0);
      src_n[7] = 1'b0; repeat (3) @(negedge clk);
      chk_pend("R2 masked pend visible", 7, 1'b1);
      chk("R2 masked irq", {31'b0, irq}, 32'h0);
      rd(3'd4, v); chk("R2 masked vector", v, 32'h0);
      src_n[7] = 1'b1; repeat (3) @(negedge clk);

      // R3, R4, R8, R9: level sweep over every source
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      for (int s = 1; s < 64; s++) begin
         src_n[s] = 1'b0; repeat (3) @(negedge clk);
         chk_pend("R3 mapping", s, 1'b1);
         rd(3'd4, v); chk("R8 vector field", v, {6'(s), 26'b0});
         chk("R9 irq raised", {31'b0, irq}, 32'h1);
         wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
         chk_pend("R4 level not clearable", s, 1'b1);
         src_n[s] = 1'b1; repeat (3) @(negedge clk);
         chk_pend("R4 level follows input", s, 1'b0);
         chk("R9 irq dropped", {31'b0, irq}, 32'h0);
      end

      // R8: source 0 is reserved, and vector writes are ignored
      src_n[0] = 1'b0; repeat (3) @(negedge clk);
      chk_pend("R8 source0 never pends", 0, 1'b0);
      wr(3'd4, 32'hFC00_0000); rd(3'd4, v); chk("R8 source0 vector", v, 32'h0);
      chk("R8 source0 irq", {31'b0, irq}, 32'h0);
      src_n[0] = 1'b1;

      // R8: priority across both banks
      src_n[5] = 1'b0; src_n[40] = 1'b0; src_n[63] = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd4, v); chk("R8 lowest wins", v, {6'd5, 26'b0});
      wr(3'd0, ~(32'h1 << x_bit(5)));
      rd(3'd4, v); chk("R8 next after mask", v, {6'd40, 26'b0});
      wr(3'd0, 32'h0);
      rd(3'd4, v); chk("R8 low bank only", v, {6'd63, 26'b0});
      wr(3'd1, 32'h0);
      rd(3'd4, v); chk("R8 all masked", v, 32'h0);
      chk("R9 all masked irq", {31'b0, irq}, 32'h0);
      src_n[5] = 1'b1; src_n[40] = 1'b1; src_n[63] = 1'b1;
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);

      // R10: level latency on source 40
      @(negedge clk); src_n[40] = 1'b0;
      @(negedge clk); chk("R10 level after 1 edge", {31'b0, irq}, 32'h0);
      @(negedge clk); chk("R10 level after 2 edges", {31'b0, irq}, 32'h1);
      src_n[40] = 1'b1; repeat (3) @(negedge clk);

      // R7: edge-select writable bits
      wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R7 edge select mask", v, 32'hFFFF_7F00);

      // R10: falling-edge latency on source 50
      @(negedge clk); src_n[50] = 1'b0;
      @(negedge clk); chk("R10 edge after 1 edge", {31'b0, irq}, 32'h0);
      @(negedge clk); chk("R10 edge after 2 edges", {31'b0, irq}, 32'h0);
      @(negedge clk); chk("R10 edge after 3 edges", {31'b0, irq}, 32'h1);
      src_n[50] = 1'b1; repeat (3) @(negedge clk);
      clear_bit(50);

      // R5, R6: edge sweep over capable sources
      for (int s = 1; s < 64; s++) begin
         if (x_edge(s)) begin
            src_n[s] = 1'b0; repeat (3) @(negedge clk);
            src_n[s] = 1'b1; repeat (3) @(negedge clk);
            chk_pend("R5 edge sticky", s, 1'b1);
            rd(3'd4, v); chk("R5 edge vector", v, {6'(s), 26'b0});
            wr(3'd2, 32'h0); wr(3'd3, 32'h0);
            chk_pend("R6 zero write keeps", s, 1'b1);
            clear_bit(s);
            chk_pend("R6 one write clears", s, 1'b0);
            chk("R6 irq after clear", {31'b0, irq}, 32'h0);
         end
      end

      // R7: non-capable sources stay level with every edge bit set
      src_n[5] = 1'b0; repeat (3) @(negedge clk);
      src_n[5] = 1'b1; repeat (3) @(negedge clk);
      chk_pend("R7 non-capable stays level", 5, 1'b0);
      src_n[30] = 1'b0; repeat (3) @(negedge clk);
      wr(3'd3, 32'hFFFF_FFFF);
      chk_pend("R7 non-capable not latched", 30, 1'b1);
      src_n[30] = 1'b1; repeat (3) @(negedge clk);
      chk_pend("R7 non-capable release", 30, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule